// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block collects 32 level-sensitive interrupt request lines and raises one interrupt toward the processor. Each source is given a 3-bit priority level by software. A level of zero turns the source off. A threshold register filters out sources whose level is too low. Each cycle the controller looks at every live request and chooses one winner: the source with the highest level, and the lowest source number when levels are equal. The winner's number can be read from a read-only status word.

Software reaches the block through a small register port. A write takes effect at the clock edge where it is presented. A read presents its address for one cycle, and the data appears on the read bus after the next clock edge. The level fields are packed four to a word. Word k carries the fields of sources 2k, 2k+1, 2k+16 and 2k+17, so a driver works out the word and the lane for a source from its number. A global enable bit gates the processor interrupt without changing the arbitration result shown in the status word.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads as zero, `irq_o` is low and the status word (offset 0xA0) reads 0x00010000.
- R2: Read data appears on `rd_data` after the clock edge that samples the read request and holds until the next read. The control word (0x00) keeps only bit 0, the threshold (0x40) keeps only bits 2:0, and a level word keeps only bits 2:0, 10:8, 18:16 and 26:24. All other bits read as zero.
- R3: Level word k, at byte offset 0x10 + 4k for k = 0 to 7, holds the level of source 2k in bits 2:0, of source 2k+1 in bits 10:8, of source 2k+16 in bits 18:16 and of source 2k+17 in bits 26:24.
- R4: A source whose level is zero never wins and never raises `irq_o`, even while its request is high.
- R5: A requesting source takes part only when its level is strictly greater than the threshold value. A threshold of 6 admits only level 7, and a threshold of 7 admits nothing.
- R6: Among the sources that take part, the one with the highest level wins.
- R7: When two or more sources that take part share the highest level, the lowest source number wins.
- R8: Status bits 4:0 hold the winning source number and bit 16 is 1 when no source takes part. In that case bits 4:0 are zero. All other status bits read as zero.
- R9: `irq_o` is high exactly when control bit 0 is set and status bit 16 is 0. Clearing control bit 0 drops `irq_o` but leaves the status word unchanged.
- R10: Requests are level-sensitive. `irq_o` and the status word follow `req_i` in the same cycle, and they follow a register write from the cycle after the write edge. A request ends when its line falls or its level is written to zero.
- R11: Writes to the status offset, to unmapped offsets and to level-word addresses that are not word-aligned change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 32 | Level-sensitive interrupt request lines, one per source |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid after the edge that sampled the read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest cases to reach from the ports are the ones where the threshold, equal levels and the split lane mapping act on one result at the same time. Examples are a tie between a low-half and a high-half source that share a level word, or a top-level source that the threshold admits at one value and blocks after one more step. Directed sequences program specific lanes of specific words and then raise chosen sets of request lines. A long pseudo-random phase then mixes register writes (including aligned, misaligned and unmapped offsets), reads and changing request patterns. A behavioural model that keeps one level per source number is compared against the outputs on every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Register byte offsets. Software depends on these values.
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_LVL0 = 8'h10;
  localparam logic [7:0] OFS_MASK = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'hA0;

  // Status word: position of the "nothing eligible" flag.
  localparam int unsigned STAT_IDLE_BIT = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LVL,
    SEL_MASK,
    SEL_STAT
  } reg_sel_e;

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NLREG = NSRC / 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [DATA_W-1:0]       status_i,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    ctrl_en,
  output logic [LVL_W-1:0]        mask_q,
  output logic [NLREG*DATA_W-1:0] lvl_flat
);

  localparam int unsigned LIDX_W = $clog2(NLREG);
  localparam int unsigned LANE   = DATA_W / 4;

  function automatic logic [DATA_W-1:0] lane_fields();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int j = 0; j < 4; j++) begin
      m[j*LANE +: LVL_W] = '1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] FLD_MASK = lane_fields();

  // Address decode
  reg_sel_e          sel;
  logic [ADDR_W-1:0] loff;
  logic [LIDX_W-1:0] lidx;

  always_comb begin
    loff = addr - ADDR_W'(OFS_LVL0);
    lidx = loff[LIDX_W+1:2];
    sel  = SEL_NONE;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      sel = SEL_CTRL;
    end else if (addr == ADDR_W'(OFS_MASK)) begin
      sel = SEL_MASK;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      sel = SEL_STAT;
    end else if ((addr >= ADDR_W'(OFS_LVL0)) && (loff < ADDR_W'(4 * NLREG)) &&
                 (loff[1:0] == 2'b00)) begin
      sel = SEL_LVL;
    end
  end

  // Write enables and next values
  logic                ctrl_we, mask_we;
  logic [NLREG-1:0]    lvl_we;
  logic                ctrl_d;
  logic [LVL_W-1:0]    mask_d;
  logic [DATA_W-1:0]   lvl_d;

  always_comb begin
    ctrl_we = wr_en && (sel == SEL_CTRL);
    mask_we = wr_en && (sel == SEL_MASK);
    ctrl_d  = wdata[0];
    mask_d  = wdata[LVL_W-1:0];
    lvl_d   = wdata & FLD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_en <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  logic [DATA_W-1:0] lvl_q [NLREG];

  for (genvar j = 0; j < NLREG; j++) begin : g_lvl
    assign lvl_we[j] = wr_en && (sel == SEL_LVL) && (lidx == LIDX_W'(j));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[j] <= '0;
      end else if (lvl_we[j]) begin
        lvl_q[j] <= lvl_d;
      end
    end

    assign lvl_flat[j*DATA_W +: DATA_W] = lvl_q[j];
  end

  // Read path: one register stage
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_CTRL: rd_d[0]         = ctrl_en;
      SEL_MASK: rd_d[LVL_W-1:0] = mask_q;
      SEL_LVL:  rd_d            = lvl_q[lidx];
      SEL_STAT: rd_d            = status_i;
      default:  rd_d            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end

endmodule

// File: rtl/prio_irq_lvlmap.sv
module prio_irq_lvlmap #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLREG = NSRC / 4
) (
  input  logic [NLREG*DATA_W-1:0] lvl_flat,
  output logic [NSRC*LVL_W-1:0]   src_lvl
);

  localparam int unsigned HALF = NSRC / 2;
  localparam int unsigned LANE = DATA_W / 4;

  // Source s lives in word (s mod HALF)/2. The lane is chosen by the odd bit
  // and by whether s is in the upper half.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned WORD = (s % HALF) / 2;
    localparam int unsigned SLOT = ((s >= HALF) ? 2 : 0) + (s % 2);
    assign src_lvl[s*LVL_W +: LVL_W] = lvl_flat[WORD*DATA_W + SLOT*LANE +: LVL_W];
  end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC*LVL_W-1:0] src_lvl,
  input  logic [LVL_W-1:0]      thresh,
  output logic                  any,
  output logic [IDX_W-1:0]      win_idx
);

  // Level 0 can never exceed a threshold of 0 or more, so a source with
  // level 0 is never eligible.
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    assign elig[s] = req[s] && (src_lvl[s*LVL_W +: LVL_W] > thresh);
  end

  // The scan runs from the highest index down with >=, so on a tie the lowest
  // index is the last one to take the slot.
  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    any      = 1'b0;
    best_lvl = '0;
    win_idx  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!any || (src_lvl[i*LVL_W +: LVL_W] >= best_lvl))) begin
        any      = 1'b1;
        best_lvl = src_lvl[i*LVL_W +: LVL_W];
        win_idx  = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);

  localparam int unsigned NLREG = NSRC / 4;
  localparam int unsigned IDX_W = $clog2(NSRC);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync[1];

  logic                    ctrl_en;
  logic [LVL_W-1:0]        mask_q;
  logic [NLREG*DATA_W-1:0] lvl_flat;
  logic [NSRC*LVL_W-1:0]   src_lvl;
  logic                    any;
  logic [IDX_W-1:0]        win_idx;
  logic [DATA_W-1:0]       status;

  prio_irq_regs #(
    .NSRC(NSRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (bus_valid && bus_write),
    .rd_en    (bus_valid && !bus_write),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .status_i (status),
    .rd_data  (rd_data),
    .ctrl_en  (ctrl_en),
    .mask_q   (mask_q),
    .lvl_flat (lvl_flat)
  );

  prio_irq_lvlmap #(
    .NSRC(NSRC), .LVL_W(LVL_W), .DATA_W(DATA_W)
  ) u_map (
    .lvl_flat (lvl_flat),
    .src_lvl  (src_lvl)
  );

  prio_irq_arb #(
    .NSRC(NSRC), .LVL_W(LVL_W)
  ) u_arb (
    .req     (req_i),
    .src_lvl (src_lvl),
    .thresh  (mask_q),
    .any     (any),
    .win_idx (win_idx)
  );

  always_comb begin
    status                = '0;
    status[IDX_W-1:0]     = any ? win_idx : '0;
    status[STAT_IDLE_BIT] = ~any;
  end

  assign irq_o = ctrl_en & any;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic                  irq_o,
  input logic                  ctrl_en,
  input logic [LVL_W-1:0]      mask_q,
  input logic [DATA_W-1:0]     status,
  input logic [NSRC*LVL_W-1:0] src_lvl,
  input logic [NSRC-1:0]       req_i,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     rd_data
);

  localparam int unsigned IDX_W = $clog2(NSRC);

  logic [DATA_W-1:0] used_bits;
  logic [IDX_W-1:0]  widx;
  logic [LVL_W-1:0]  wlv;
  logic              idle;

  always_comb begin
    used_bits                = '0;
    used_bits[IDX_W-1:0]     = '1;
    used_bits[STAT_IDLE_BIT] = 1'b1;
  end

  assign idle = status[STAT_IDLE_BIT];
  assign widx = status[IDX_W-1:0];
  assign wlv  = src_lvl[widx*LVL_W +: LVL_W];

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |-> ctrl_en);

  a_r9_irq_when_pending: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctrl_en && !idle) |-> irq_o);

  a_r8_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    idle |-> (widx == '0));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status & ~used_bits) == '0);

  a_r4_winner_live: assert property (@(posedge clk) disable iff (!rst_q_n)
    !idle |-> (req_i[widx] && (wlv != '0)));

  a_r5_winner_above_mask: assert property (@(posedge clk) disable iff (!rst_q_n)
    !idle |-> (wlv > mask_q));

  a_r2_ctrl_read_clean: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_valid && !bus_write && (bus_addr == ADDR_W'(OFS_CTRL))) |=>
      (rd_data[DATA_W-1:1] == '0));

  a_r2_read_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bus_valid || bus_write) |=> $stable(rd_data));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .irq_o     (irq_o),
  .ctrl_en   (ctrl_en),
  .mask_q    (mask_q),
  .status    (status),
  .src_lvl   (src_lvl),
  .req_i     (req_i),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .rd_data   (rd_data)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

  logic        clk;
  logic        rst_n;
  logic [31:0] req_i;
  logic        bus_valid;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data;
  logic        irq_o;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit chk_on = 0;
  bit done   = 0;

  // Behavioural model: one level per source number
  int          lv [32];
  int          m_en;
  int          m_mask;
  logic [31:0] rd_exp;

  function automatic logic [31:0] m_status(logic [31:0] r);
    int best = -1;
    int idx  = 0;
    for (int s = 0; s < 32; s++) begin
      if (r[s] && lv[s] > m_mask && lv[s] > best) begin
        best = lv[s];
        idx  = s;
      end
    end
    return (best < 0) ? 32'h0001_0000 : 32'(idx);
  endfunction

  function automatic bit is_lvl(int a);
    return (a >= 16) && (a <= 44) && (a % 4 == 0);
  endfunction

  function automatic logic [31:0] m_read(int a, logic [31:0] r);
    int k;
    if (a == 0)    return 32'(m_en);
    if (a == 64)   return 32'(m_mask);
    if (a == 160)  return m_status(r);
    if (is_lvl(a)) begin
      k = (a - 16) / 4;
      return 32'(lv[2*k]) | (32'(lv[2*k+1]) << 8) |
             (32'(lv[2*k+16]) << 16) | (32'(lv[2*k+17]) << 24);
    end
    return 32'h0;
  endfunction

  task automatic m_write(int a, logic [31:0] d);
    int k;
    if (a == 0)  m_en   = int'(d[0]);
    if (a == 64) m_mask = int'(d[2:0]);
    if (is_lvl(a)) begin
      k = (a - 16) / 4;
      lv[2*k]    = int'(d[2:0]);
      lv[2*k+1]  = int'(d[10:8]);
      lv[2*k+16] = int'(d[18:16]);
      lv[2*k+17] = int'(d[26:24]);
    end
  endtask

  task automatic m_clear();
    for (int s = 0; s < 32; s++) lv[s] = 0;
    m_en   = 0;
    m_mask = 0;
    rd_exp = 32'h0;
  endtask

  initial m_clear();

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear();
    end else if (bus_valid) begin
      if (bus_write) m_write(int'(bus_addr), bus_wdata);
      else           rd_exp = m_read(int'(bus_addr), req_i);
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Comparison against the model on every cycle
  always @(negedge clk) begin
    if (chk_on) begin
      #1;
      check("R9 irq vs model", {31'b0, irq_o},
            {31'b0, (m_en != 0) && !m_status(req_i)[16]});
      check("R2 read data vs model", rd_data, rd_exp);
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic set_req(logic [31:0] v);
    @(negedge clk);
    req_i = v;
  endtask

  task automatic exp_irq(logic e, string tag);
    @(negedge clk);
    #1;
    check(tag, {31'b0, irq_o}, {31'b0, e});
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    int          pick;
    logic [7:0]  alist [12];
    alist = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
              8'h2C, 8'h40, 8'hA0, 8'h44};

    rst_n = 1'b0; req_i = '0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_on = 1;

    // R1 reset state
    exp_irq(1'b0, "R1 irq after reset");
    bus_rd(8'hA0, 32'h0001_0000, "R1 status after reset");
    bus_rd(8'h00, 32'h0, "R1 control after reset");
    bus_rd(8'h18, 32'h0, "R1 level word after reset");

    // R2 field widths and read timing
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, 32'h1, "R2 control keeps bit 0");
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_rd(8'h40, 32'h7, "R2 threshold keeps 3 bits");
    bus_wr(8'h1C, 32'hFFFF_FFFF);
    bus_rd(8'h1C, 32'h0707_0707, "R2 level word lanes");
    bus_wr(8'h40, 32'h0);
    bus_wr(8'h1C, 32'h0);

    // R3 lane mapping: word 2 -> sources 4,5,20,21 at levels 1,3,2,4
    bus_wr(8'h18, 32'h0402_0301);
    bus_rd(8'h18, 32'h0402_0301, "R3 level word readback");
    set_req(32'h1 << 21); bus_rd(8'hA0, 32'd21, "R3 source 21 lane");
    exp_irq(1'b1, "R9 irq with eligible source");
    set_req(32'h1 << 20); bus_rd(8'hA0, 32'd20, "R3 source 20 lane");
    set_req(32'h1 << 5);  bus_rd(8'hA0, 32'd5,  "R3 source 5 lane");
    set_req(32'h1 << 4);  bus_rd(8'hA0, 32'd4,  "R3 source 4 lane");

    // R4 level zero disables
    set_req(32'h1 << 6);
    bus_rd(8'hA0, 32'h0001_0000, "R4 zero-level source ignored");
    exp_irq(1'b0, "R4 no irq from zero-level source");

    // R6 highest level
    set_req(32'h0030_0030); bus_rd(8'hA0, 32'd21, "R6 level 4 beats 1,3,2");
    set_req(32'h0010_0030); bus_rd(8'hA0, 32'd5,  "R6 level 3 beats 1,2");

    // R7 ties: sources 0 and 17 at level 4
    bus_wr(8'h10, 32'h0400_0004);
    set_req(32'h0022_0001); bus_rd(8'hA0, 32'd0,  "R7 tie picks lowest (0)");
    set_req(32'h0022_0000); bus_rd(8'hA0, 32'd17, "R7 tie picks lowest (17)");

    // R5 threshold
    bus_wr(8'h40, 32'd4);
    set_req(32'h0032_0031);
    bus_rd(8'hA0, 32'h0001_0000, "R5 levels at threshold blocked");
    exp_irq(1'b0, "R5 no irq at threshold");
    bus_wr(8'h2C, 32'h0700_0000);
    set_req(32'h8032_0031); bus_rd(8'hA0, 32'd31, "R5 level 7 over 4");
    bus_wr(8'h40, 32'd6);   bus_rd(8'hA0, 32'd31, "R5 level 7 over 6");
    bus_wr(8'h2C, 32'h0600_0000);
    bus_rd(8'hA0, 32'h0001_0000, "R5 level 6 blocked by 6");
    bus_wr(8'h40, 32'd5);   bus_rd(8'hA0, 32'd31, "R5 level 6 over 5");
    bus_wr(8'h40, 32'd0);

    // R9 global enable
    bus_wr(8'h00, 32'h0);
    set_req(32'h1 << 21);
    exp_irq(1'b0, "R9 irq gated by enable");
    bus_rd(8'hA0, 32'd21, "R9 status unaffected by enable");
    bus_wr(8'h00, 32'h1);
    exp_irq(1'b1, "R9 irq after enable");

    // R10 level-sensitive release
    set_req(32'h0);
    exp_irq(1'b0, "R10 irq drops with request");
    set_req(32'h1 << 21);
    exp_irq(1'b1, "R10 irq follows request");
    bus_wr(8'h18, 32'h0002_0301);
    exp_irq(1'b0, "R10 irq drops when level cleared");
    bus_rd(8'hA0, 32'h0001_0000, "R10 status idle after clear");

    // R11 ignored writes
    bus_wr(8'hA0, 32'hFFFF_FFFF);
    bus_wr(8'h44, 32'hFFFF_FFFF);
    bus_wr(8'h12, 32'hFFFF_FFFF);
    bus_rd(8'h18, 32'h0002_0301, "R11 level word untouched");
    bus_rd(8'h10, 32'h0400_0004, "R11 misaligned write ignored");
    bus_rd(8'h40, 32'h0, "R11 threshold untouched");
    bus_rd(8'h00, 32'h1, "R11 control untouched");
    bus_rd(8'h44, 32'h0, "R11 unmapped read zero");
    set_req(32'h1 << 4);
    bus_rd(8'hA0, 32'd4, "R11 status after ignored writes");

    // R8 and all others: random traffic checked against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      seed = seed * 32'd1103515245 + 32'd12345;
      pick = int'(seed[27:24]) % 12;
      bus_valid = seed[30];
      bus_write = seed[29];
      bus_addr  = (seed[23:20] == 4'hF) ? 8'h12 : alist[pick];
      seed = seed * 32'd1103515245 + 32'd12345;
      bus_wdata = (bus_addr == 8'h40) ? {29'b0, seed[31:30] == 2'b11, seed[21:20]}
                                      : seed;
      if (bus_addr == 8'h00) bus_wdata[0] = seed[7] | seed[9];
      seed = seed * 32'd1103515245 + 32'd12345;
      if (seed[3:2] == 2'b00) req_i = seed ^ {seed[15:0], seed[31:16]};
    end
    @(negedge clk);
    bus_valid = 1'b0;
    bus_rd(8'hA0, m_status(req_i), "R8 final status");
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule